// File: doc/BRIEF.md
# I2C Register Port Slave

This block is an I2C target that lets a bus master load and read back a small bank of eight 8-bit configuration registers. It runs on a fast system clock and oversamples SCL and SDA through synchronizers, so the bus can run with no fixed relation to that clock. SDA is open-drain. The block never drives it high. It only asserts an output enable that pulls the line low.

The seven-bit device address is the fixed prefix `00100` followed by two strap pins. A write transaction sends a pointer byte first and then any number of data bytes. The pointer byte selects a register and can turn on auto-increment. A read transaction starts returning the register under the current pointer straight after the address byte. The pointer keeps its value between transactions. Every register is also presented in parallel on `cfg_regs` for the logic that the block configures.

The SCL/SDA pair is a two-wire serial bus with no handshake at the clock level. The block applies no back-pressure and does not stretch SCL. Each byte is accepted or supplied within the SCL low phase that follows it.

Top module: `i2c_regport`

## Requirements
- R1: A START condition (SDA falling while SCL is high) begins a new transaction expecting an address byte, in any state, including in the middle of a byte. A STOP condition (SDA rising while SCL is high) ends the transaction and releases SDA. A byte cut short by STOP changes no register.
- R2: The address byte is sent MSB first. It is seven address bits, `0,0,1,0,0,strap_a1,strap_a0`, followed by a R/W bit that is 1 for a read and 0 for a write. On a match the block acknowledges by holding `sda_oe`=1 through the ninth SCL clock.
- R3: After an address that does not match, the block gives no acknowledge and changes no register. It keeps SDA released until the next START.
- R4: In a write, the first byte after the address is the pointer byte, and it is acknowledged. Bit 7 enables auto-increment, bits 2:0 select the register, and bits 6:3 are ignored.
- R5: Each later byte of a write is stored in the selected register and acknowledged. Register i appears on `cfg_regs[8*i+7:8*i]`.
- R6: With auto-increment on, the pointer advances by one after every data byte written or read, wrapping from 7 to 0. With auto-increment off, the pointer stays where it is.
- R7: In a read, the selected register is shifted out MSB first, starting in the clock after the address acknowledge. SDA is released during the ninth clock of each byte.
- R8: In a read, an acknowledge from the master (SDA low on the ninth clock) makes the block send another byte, from the current pointer. A NACK makes the block stop driving until the next START.
- R9: After reset all registers are 0, the pointer is 1, auto-increment is off, and `sda_oe` is 0.
- R10: `sda_oe` changes only while SCL is low.
- R11: The pointer keeps its value across STOP and START. A read that follows a write carrying only a pointer byte returns the register that pointer selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_a1 | input | 1 | Address bit 1, strapped by the board |
| strap_a0 | input | 1 | Address bit 0, strapped by the board |
| cfg_regs | output | 64 | All eight registers in parallel, register i at bits 8i+7:8i |

## Verification
The hardest case to reach from the ports is a multi-byte read with auto-increment on whose pointer crosses from register 7 to register 0. Reaching it first needs a burst write that wraps, and then a separate pointer-only write that parks the pointer at 6. Only after that can the read acknowledge twice and NACK the third byte. The bench builds this sequence so that the wrap is checked in both directions. It also checks that SDA is released after the NACK. Further tasks exercise two cut-short cases: a STOP arriving half-way through a data byte, and a repeated START between the pointer write and the read.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam logic [4:0] DEV_PREFIX = 5'b00100;
  localparam int         BYTE_W     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } port_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int       W       = 2,
  parameter int       STAGES  = 2,
  parameter bit       RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= {W{RST_VAL}};
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int AW = 3,
  parameter int DW = 8,
  localparam int NREG = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DW-1:0]     rdata,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (we && waddr == AW'(i)) mem[i] <= wdata;
    end
    assign flat[i*DW +: DW] = mem[i];
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int            AW      = 3,
  parameter logic [AW-1:0] PTR_RST = AW'(1),
  localparam int           NREG    = 1 << AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic                   strap_a1,
  input  logic                   strap_a0,
  output logic [NREG*BYTE_W-1:0] cfg_regs
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start, stop;

  port_state_t       st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic [AW-1:0]     ptr;
  logic              inc;
  logic              nack;
  logic [BYTE_W-1:0] rdata;
  logic              wr_en;
  logic [6:0]        my_addr;

  i2c_line_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    ({scl_s, sda_s})
  );

  i2c_bus_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start   (start),
    .stop    (stop)
  );

  assign my_addr = {DEV_PREFIX, strap_a1, strap_a0};
  assign wr_en   = (st == ST_WDAT) && scl_fall && (cnt == 4'd8);

  i2c_regbank #(.AW(AW), .DW(BYTE_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .waddr(ptr),
    .wdata(sh),
    .raddr(ptr),
    .rdata(rdata),
    .flat (cfg_regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= PTR_RST;
      inc    <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise) begin
            if (cnt < 4'd8) sh <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          if (scl_fall && cnt == 4'd8) begin
            if (st == ST_ADDR && sh[7:1] != my_addr) begin
              st <= ST_SKIP;
            end else begin
              sda_oe <= 1'b1;
            end
            if (st == ST_PTR) begin
              ptr <= sh[AW-1:0];
              inc <= sh[7];
            end
            if (st == ST_WDAT && inc) ptr <= ptr + AW'(1);
          end
          if (scl_fall && cnt == 4'd9) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (st == ST_ADDR) begin
              if (sh[0]) begin
                st     <= ST_RDAT;
                sh     <= rdata;
                sda_oe <= ~rdata[7];
              end else begin
                st <= ST_PTR;
              end
            end else if (st == ST_PTR) begin
              st <= ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd8) begin
              nack <= sda_s;
              if (inc) ptr <= ptr + AW'(1);
            end
          end
          if (scl_fall) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[6];
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
            end else if (cnt == 4'd9) begin
              cnt <= '0;
              if (nack) begin
                st     <= ST_SKIP;
                sda_oe <= 1'b0;
              end else begin
                sh     <= rdata;
                sda_oe <= ~rdata[7];
              end
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
  import i2c_regport_pkg::*;
#(
  parameter int RW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          scl_fall,
  input logic          start,
  input logic          stop,
  input logic          sda_oe,
  input port_state_t   st,
  input logic [3:0]    cnt,
  input logic [RW-1:0] cfg_regs
);
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == ST_ADDR && cnt == 4'd0 && !sda_oe)); // R1

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == ST_IDLE && !sda_oe)); // R1

  AST_QUIET_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe); // R3

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R10

  AST_REG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_regs != $past(cfg_regs)) |-> $past(scl_fall)); // R5
endmodule

bind i2c_regport i2c_regport_chk #(.RW(NREG*i2c_regport_pkg::BYTE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_s   (scl_s),
  .scl_fall(scl_fall),
  .start   (start),
  .stop    (stop),
  .sda_oe  (sda_oe),
  .st      (st),
  .cnt     (cnt),
  .cfg_regs(cfg_regs)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic strap_a1 = 1'b1;
  logic strap_a0 = 1'b0;
  logic sda_oe;
  logic [63:0] cfg_regs;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0;
  int n_fail = 0;
  int oe_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [8];

  always #2 clk = ~clk;

  i2c_regport uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .sda_oe  (sda_oe),
    .strap_a1(strap_a1),
    .strap_a0(strap_a0),
    .cfg_regs(cfg_regs)
  );

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) oe_bad++;
    prev_oe <= sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 8; i++) check(tag, cfg_regs[i*8 +: 8], exp_r[i]);
  endtask

  task automatic bus_start();
    if (!scl) begin
      wait_clk(H/2); sda_m = 1'b1; wait_clk(H/2); scl = 1'b1; wait_clk(H);
    end
    sda_m = 1'b0; wait_clk(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(H/2); sda_m = 1'b0; wait_clk(H/2); scl = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wait_clk(H/2); sda_m = b[i]; wait_clk(H/2);
      scl = 1'b1; wait_clk(H); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    wait_clk(H/2); sda_m = 1'b1; wait_clk(H/2);
    scl = 1'b1; wait_clk(H/2); @(negedge clk); ack = !sda_line;
    wait_clk(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      wait_clk(H/2); sda_m = 1'b1; wait_clk(H/2);
      scl = 1'b1; wait_clk(H/2); @(negedge clk); b = {b[6:0], sda_line};
      wait_clk(H/2); scl = 1'b0;
    end
    wait_clk(H/2); sda_m = mack ? 1'b0 : 1'b1; wait_clk(H/2);
    scl = 1'b1; wait_clk(H); scl = 1'b0;
    wait_clk(H/2); sda_m = 1'b1;
  endtask

  task automatic set_pointer(input logic [7:0] p);
    bit a;
    bus_start();
    send_byte(8'h24, a); check("R2 addr ack", a, 1);
    send_byte(p, a);     check("R4 ptr ack", a, 1);
    bus_stop();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 sda_oe", sda_oe, 0);
    check("R9 regs", cfg_regs, 64'h0);
  endtask

  task automatic t_write_basic();
    bit a;
    bus_start();
    send_byte(8'h24, a); check("R2 addr ack", a, 1);
    send_byte(8'h03, a); check("R4 ptr ack", a, 1);
    send_byte(8'hA5, a); check("R5 data ack", a, 1);
    bus_stop();
    exp_r[3] = 8'hA5;
    @(negedge clk);
    check_regs("R5 write");
    check("R1 released after stop", sda_oe, 0);
  endtask

  task automatic t_write_autoinc();
    bit a;
    bus_start();
    send_byte(8'h24, a);
    send_byte(8'hFE, a); check("R4 ptr reserved set ack", a, 1);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a); check("R6 wrap ack", a, 1);
    bus_stop();
    exp_r[6] = 8'h11; exp_r[7] = 8'h22; exp_r[0] = 8'h33;
    @(negedge clk);
    check_regs("R6 autoinc write wrap");
  endtask

  task automatic t_write_noinc();
    bit a;
    bus_start();
    send_byte(8'h24, a);
    send_byte(8'h02, a);
    send_byte(8'h44, a);
    send_byte(8'h55, a);
    bus_stop();
    exp_r[2] = 8'h55;
    @(negedge clk);
    check_regs("R6 no autoinc");
  endtask

  task automatic t_bad_addr();
    bit a;
    bus_start();
    send_byte(8'h20, a); check("R3 no ack on mismatch", a, 0);
    send_byte(8'h03, a); check("R3 ignored byte", a, 0);
    send_byte(8'hEE, a); check("R3 ignored byte", a, 0);
    bus_stop();
    @(negedge clk);
    check_regs("R3 regs untouched");
  endtask

  task automatic t_ptr_persist();
    bit a; logic [7:0] d;
    set_pointer(8'h03);
    bus_start();
    send_byte(8'h25, a); check("R7 read addr ack", a, 1);
    recv_byte(1'b0, d);  check("R11 pointer kept", d, 8'hA5);
    bus_stop();
  endtask

  task automatic t_read_burst();
    bit a; logic [7:0] d;
    set_pointer(8'h86);
    bus_start();
    send_byte(8'h25, a);
    recv_byte(1'b1, d); check("R7 read reg6", d, 8'h11);
    recv_byte(1'b1, d); check("R8 read reg7", d, 8'h22);
    recv_byte(1'b0, d); check("R6 read wrap reg0", d, 8'h33);
    wait_clk(H/2); @(negedge clk);
    check("R8 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_read_noinc();
    bit a; logic [7:0] d;
    set_pointer(8'h02);
    bus_start();
    send_byte(8'h25, a);
    recv_byte(1'b1, d); check("R8 read same reg", d, 8'h55);
    recv_byte(1'b0, d); check("R8 read same reg again", d, 8'h55);
    bus_stop();
  endtask

  task automatic t_repeated_start();
    bit a; logic [7:0] d;
    bus_start();
    send_byte(8'h24, a);
    send_byte(8'h07, a);
    bus_start();
    send_byte(8'h25, a); check("R1 addr ack after repeated start", a, 1);
    recv_byte(1'b0, d);  check("R1 read after repeated start", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_abort();
    bit a;
    bus_start();
    send_byte(8'h24, a);
    send_byte(8'h04, a);
    send_bits(8'hC3, 4);
    bus_stop();
    @(negedge clk);
    check_regs("R1 cut-short byte");
    check("R1 released", sda_oe, 0);
  endtask

  task automatic t_strap();
    bit a;
    strap_a1 = 1'b0; strap_a0 = 1'b1;
    wait_clk(4);
    bus_start();
    send_byte(8'h24, a); check("R3 old address rejected", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h22, a); check("R2 strapped address ack", a, 1);
    send_byte(8'h01, a);
    send_byte(8'h7E, a);
    bus_stop();
    exp_r[1] = 8'h7E;
    @(negedge clk);
    check_regs("R2 write via new address");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_r[i] = 8'h00;
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_write_basic();
    t_write_autoinc();
    t_write_noinc();
    t_bad_addr();
    t_ptr_persist();
    t_read_burst();
    t_read_noinc();
    t_repeated_start();
    t_abort();
    t_strap();
    check("R10 oe changes only with SCL low", oe_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule